// File: doc/BRIEF.md
# Prioritized Autovector Interrupt Controller

This block merges sixteen peripheral event lines into one interrupt output for a small processor core whose interrupt input responds to edges. Every event line owns a request latch. Hardware sets the latch, and software clears it by writing a one to its bit. A per-source enable masks each latch. A fixed-priority encoder selects the pending, enabled source with the lowest index and presents it as a vector byte.

Whenever an enabled request newly appears, the block emits a one-cycle pulse toward the processor and sets a summary flag. Software clears that flag by writing a zero to it. When software clears one source while other enabled requests remain, a fresh pulse announces the next one, so queued events are never hidden behind a single edge. With autovectoring switched on, the vector byte replaces the program-memory byte fetched from one fixed address, so each source dispatches directly to its own handler.

Registers are reached over a four-word bus with single-cycle writes. Reads are registered: `bus_rdata` shows the register selected by `bus_addr` one clock later.

Top module: `irq_autovec_ctrl`

## Requirements
- R1: An event on `src_evt[i]` sets pending bit i at the next clock edge. The pending word reads at bus address 0, with bit i for source i.
- R2: A bus write to address 0 clears every pending bit whose write-data bit is 1. Bits written with 0 keep their value.
- R3: If an event and a write-1 clear reach the same pending bit in the same cycle, the bit stays set.
- R4: The enable word is read/write at address 1, with bit i for source i. The vector byte at address 2 carries the lowest index among the bits set in both the pending and the enable words, placed in bits [5:2]. All its other bits are zero. When no such bit exists, the vector byte reads as zero.
- R5: `cpu_irq` is high for one cycle directly after any clock edge at which a pending-and-enabled bit newly appears. This covers an event on an enabled source and also enabling a source that is already pending.
- R6: If a write-1 clear removes a pending-and-enabled bit while another pending-and-enabled bit remains, `cpu_irq` is high for one cycle directly after that edge.
- R7: No pulse occurs when no pending-and-enabled bit results. This includes an event on a disabled source, and clearing the last enabled request.
- R8: Every pulse sets the summary flag `agg_flag`, which also reads as bit 1 at address 3. A write to address 3 with bit 1 at 0 clears the flag, and bit 1 at 1 leaves it unchanged. A pulse in the same cycle wins over the clear.
- R9: Bit 0 at address 3 enables autovectoring. While it is set and `fetch_addr` equals 0x0045, `fetch_data` carries the vector byte. Otherwise `fetch_data` equals `mem_data`. The path is combinational.
- R10: After reset, pending, enable, vector, control, `cpu_irq` and `agg_flag` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_evt | input | 16 | Per-source event strobes |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| cpu_irq | output | 1 | Interrupt pulse to the processor |
| agg_flag | output | 1 | Summary request flag |
| fetch_addr | input | 16 | Program-fetch address |
| mem_data | input | 8 | Byte from program memory |
| fetch_data | output | 8 | Byte delivered to the processor |

## Verification
Two collisions are provoked: a hardware event and a software clear landing in the same cycle. An event is driven on a source while the same cycle writes a one to that source's pending bit, and the latch must read back as pending. A new request pulse is also raised in the same cycle as a zero-write to the summary flag, and the flag must remain set. Both cases are judged through bus reads and the `agg_flag` port after the edge. Each is also covered by a property on the latch and flag state.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    RA_PEND = 2'd0,
    RA_EN   = 2'd1,
    RA_VEC  = 2'd2,
    RA_CTRL = 2'd3
  } reg_addr_e;

  localparam int CTRL_AV_BIT  = 0;
  localparam int CTRL_AGG_BIT = 1;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int NSRC = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] pend_q,
  output logic [NSRC-1:0] pend_nxt
);
  for (genvar i = 0; i < NSRC; i++) begin : g_latch
    always_comb pend_nxt[i] = set_i[i] | (pend_q[i] & ~clr_i[i]);

    always_ff @(posedge clk) begin
      if (rst) pend_q[i] <= 1'b0;
      else     pend_q[i] <= pend_nxt[i];
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int NSRC  = 16,
  parameter int IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]  req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
    any_o = |req_i;
  end
endmodule

// File: rtl/irq_pulse_gen.sv
module irq_pulse_gen #(
  parameter int NSRC = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] g_now,
  input  logic [NSRC-1:0] g_nxt,
  input  logic [NSRC-1:0] clr_i,
  input  logic [NSRC-1:0] set_i,
  input  logic            agg_clr_i,
  output logic            pulse_q,
  output logic            agg_q
);
  logic fresh;
  logic clr_hit;
  logic fire;

  always_comb begin
    fresh   = |(g_nxt & ~g_now);
    clr_hit = |(g_now & clr_i & ~set_i);
    fire    = fresh | (clr_hit & (|g_nxt));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q <= 1'b0;
      agg_q   <= 1'b0;
    end else begin
      pulse_q <= fire;
      if (fire)           agg_q <= 1'b1;
      else if (agg_clr_i) agg_q <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_autovec_ctrl.sv
module irq_autovec_ctrl #(
  parameter int          NSRC    = 16,
  parameter int          FADDR_W = 16,
  parameter int          BYTE_W  = 8,
  parameter logic [15:0] AV_ADDR = 16'h0045
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NSRC-1:0]    src_evt,
  input  logic               bus_wr,
  input  logic [1:0]         bus_addr,
  input  logic [NSRC-1:0]    bus_wdata,
  output logic [NSRC-1:0]    bus_rdata,
  output logic               cpu_irq,
  output logic               agg_flag,
  input  logic [FADDR_W-1:0] fetch_addr,
  input  logic [BYTE_W-1:0]  mem_data,
  output logic [BYTE_W-1:0]  fetch_data
);
  import irq_pkg::*;

  localparam int IDX_W = $clog2(NSRC);
  localparam int PAD_W = BYTE_W - IDX_W - 2;

  logic [NSRC-1:0]   pend_q;
  logic [NSRC-1:0]   pend_nxt;
  logic [NSRC-1:0]   en_q;
  logic [NSRC-1:0]   en_nxt;
  logic [NSRC-1:0]   clr_mask;
  logic [NSRC-1:0]   g_now;
  logic [NSRC-1:0]   g_nxt;
  logic              av_en_q;
  logic              agg_clr;
  logic              any_nxt;
  logic [IDX_W-1:0]  idx_nxt;
  logic [BYTE_W-1:0] vec_q;
  logic              wr_pend;
  logic              wr_en;
  logic              wr_ctrl;

  always_comb begin
    wr_pend  = bus_wr && (bus_addr == RA_PEND);
    wr_en    = bus_wr && (bus_addr == RA_EN);
    wr_ctrl  = bus_wr && (bus_addr == RA_CTRL);
    clr_mask = wr_pend ? bus_wdata : '0;
    en_nxt   = wr_en ? bus_wdata : en_q;
    agg_clr  = wr_ctrl && !bus_wdata[CTRL_AGG_BIT];
    g_now    = pend_q & en_q;
    g_nxt    = pend_nxt & en_nxt;
  end

  irq_src_bank #(.NSRC(NSRC)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .set_i   (src_evt),
    .clr_i   (clr_mask),
    .pend_q  (pend_q),
    .pend_nxt(pend_nxt)
  );

  irq_prio_enc #(.NSRC(NSRC), .IDX_W(IDX_W)) u_enc (
    .req_i(g_nxt),
    .any_o(any_nxt),
    .idx_o(idx_nxt)
  );

  irq_pulse_gen #(.NSRC(NSRC)) u_pulse (
    .clk      (clk),
    .rst      (rst),
    .g_now    (g_now),
    .g_nxt    (g_nxt),
    .clr_i    (clr_mask),
    .set_i    (src_evt),
    .agg_clr_i(agg_clr),
    .pulse_q  (cpu_irq),
    .agg_q    (agg_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      av_en_q <= 1'b0;
      vec_q   <= '0;
    end else begin
      en_q  <= en_nxt;
      vec_q <= any_nxt ? {PAD_W'(0), idx_nxt, 2'b00} : '0;
      if (wr_ctrl) av_en_q <= bus_wdata[CTRL_AV_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        RA_PEND: bus_rdata <= pend_q;
        RA_EN:   bus_rdata <= en_q;
        RA_VEC:  bus_rdata <= NSRC'(vec_q);
        default: bus_rdata <= NSRC'({agg_flag, av_en_q});
      endcase
    end
  end

  always_comb begin
    if (av_en_q && (fetch_addr == AV_ADDR[FADDR_W-1:0])) fetch_data = vec_q;
    else                                                 fetch_data = mem_data;
  end
endmodule

// File: rtl/irq_autovec_ctrl_chk.sv
module irq_autovec_ctrl_chk #(
  parameter int NSRC    = 16,
  parameter int FADDR_W = 16,
  parameter int BYTE_W  = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [NSRC-1:0]    src_evt,
  input logic               bus_wr,
  input logic [1:0]         bus_addr,
  input logic [NSRC-1:0]    bus_wdata,
  input logic [NSRC-1:0]    pend,
  input logic [NSRC-1:0]    en,
  input logic [BYTE_W-1:0]  vec,
  input logic               cpu_irq,
  input logic               agg_flag,
  input logic               av_en,
  input logic [FADDR_W-1:0] fetch_addr,
  input logic [BYTE_W-1:0]  mem_data,
  input logic [BYTE_W-1:0]  fetch_data
);
  localparam int IDX_W = $clog2(NSRC);

  logic [NSRC-1:0]  clr;
  logic [NSRC-1:0]  gated;
  logic [IDX_W-1:0] vidx;
  logic [NSRC-1:0]  below;
  logic             ctrl_clr;

  always_comb begin
    clr      = (bus_wr && bus_addr == 2'd0) ? bus_wdata : '0;
    gated    = pend & en;
    vidx     = vec[IDX_W+1:2];
    below    = (NSRC'(1) << vidx) - NSRC'(1);
    ctrl_clr = bus_wr && bus_addr == 2'd3 && !bus_wdata[1];
  end

  // R1 and R3: an event always leaves its latch set
  a_r1_evt_sets: assert property (@(posedge clk) disable iff (rst)
    (|src_evt) |=> ((pend & $past(src_evt)) == $past(src_evt)));

  // R2: written ones clear when no event collides
  a_r2_clear_one: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 2'd0) |=> ((pend & $past(bus_wdata & ~src_evt)) == '0));

  // R2: bits not written with one are retained
  a_r2_keep_rest: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend & $past(pend & ~clr)) == $past(pend & ~clr)));

  // R4: vector reports the lowest gated index
  a_r4_prio: assert property (@(posedge clk) disable iff (rst)
    (|gated) |-> (gated[vidx] && ((gated & below) == '0)));

  // R4: empty vector when nothing gated
  a_r4_zero: assert property (@(posedge clk) disable iff (rst)
    (gated == '0) |-> (vec == '0));

  // R7: a pulse only with a gated request present
  a_r7_pulse_needs_req: assert property (@(posedge clk) disable iff (rst)
    cpu_irq |-> (|gated));

  // R8: pulse always accompanied by the summary flag
  a_r8_pulse_sets_flag: assert property (@(posedge clk) disable iff (rst)
    cpu_irq |-> agg_flag);

  // R8: flag only rises together with a pulse
  a_r8_flag_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(agg_flag) |-> cpu_irq);

  // R8: flag drops only after a zero-write
  a_r8_flag_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(agg_flag) |-> $past(ctrl_clr));

  // R9: passthrough whenever substitution is off
  a_r9_pass: assert property (@(posedge clk) disable iff (rst)
    (!av_en || fetch_addr != FADDR_W'(16'h0045)) |-> (fetch_data == mem_data));
endmodule

bind irq_autovec_ctrl irq_autovec_ctrl_chk #(
  .NSRC(NSRC), .FADDR_W(FADDR_W), .BYTE_W(BYTE_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .src_evt   (src_evt),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .pend      (pend_q),
  .en        (en_q),
  .vec       (vec_q),
  .cpu_irq   (cpu_irq),
  .agg_flag  (agg_flag),
  .av_en     (av_en_q),
  .fetch_addr(fetch_addr),
  .mem_data  (mem_data),
  .fetch_data(fetch_data)
);

// File: tb/irq_autovec_ctrl_test.sv
`timescale 1ns/1ps
module irq_autovec_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] src_evt = '0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        cpu_irq;
  logic        agg_flag;
  logic [15:0] fetch_addr = '0;
  logic [7:0]  mem_data = '0;
  logic [7:0]  fetch_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_autovec_ctrl uut (
    .clk(clk), .rst(rst), .src_evt(src_evt), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_irq(cpu_irq), .agg_flag(agg_flag), .fetch_addr(fetch_addr),
    .mem_data(mem_data), .fetch_data(fetch_data)
  );

  // mask, enable, expected vector byte
  localparam logic [15:0] T_MASK [6] = '{16'h0001, 16'h8000, 16'h0F00, 16'hA000, 16'h0010, 16'hFFFF};
  localparam logic [15:0] T_EN   [6] = '{16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h7FFF, 16'hFFEF, 16'hFFFE};
  localparam logic [7:0]  T_VEC  [6] = '{8'h00,    8'h3C,    8'h20,    8'h34,    8'h00,    8'h04};

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic edge_s();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    edge_s();
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    edge_s();
    d = bus_rdata;
  endtask

  task automatic evt(input logic [15:0] m);
    @(negedge clk);
    src_evt = m;
    edge_s();
    @(negedge clk);
    src_evt = '0;
  endtask

  initial begin
    logic [15:0] r;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R10 reset state
    chk("R10 cpu_irq", {15'd0, cpu_irq}, 16'd0);
    chk("R10 agg_flag", {15'd0, agg_flag}, 16'd0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), r);
      chk("R10 register", r, 16'd0);
    end

    // table walk: R1 R4 R5 R7
    for (int i = 0; i < 6; i++) begin
      wr(2'd1, T_EN[i]);
      @(negedge clk);
      src_evt = T_MASK[i];
      edge_s();
      chk("R5 pulse on event", {15'd0, cpu_irq}, {15'd0, |(T_MASK[i] & T_EN[i])});
      @(negedge clk);
      src_evt = '0;
      edge_s();
      chk("R5 pulse one cycle", {15'd0, cpu_irq}, 16'd0);
      rd(2'd2, r);
      chk("R4 vector", r, {8'd0, T_VEC[i]});
      rd(2'd0, r);
      chk("R1 pending", r, T_MASK[i]);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 16'hFFFF;
      edge_s();
      chk("R7 no pulse on last clear", {15'd0, cpu_irq}, 16'd0);
      @(negedge clk);
      bus_wr = 1'b0;
      wr(2'd3, 16'h0000);
    end

    // R7 disabled source gives no pulse
    wr(2'd1, 16'h0000);
    @(negedge clk);
    src_evt = 16'h0024;
    edge_s();
    chk("R7 disabled event", {15'd0, cpu_irq}, 16'd0);
    @(negedge clk);
    src_evt = '0;
    // R2 write zero no effect, write one clears
    wr(2'd0, 16'h0000);
    rd(2'd0, r);
    chk("R2 write zero keeps", r, 16'h0024);
    wr(2'd0, 16'h0004);
    rd(2'd0, r);
    chk("R2 write one clears", r, 16'h0020);
    wr(2'd0, 16'hFFFF);

    // R3 set wins over same-cycle clear
    @(negedge clk);
    src_evt = 16'h0040; bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 16'h0040;
    edge_s();
    @(negedge clk);
    src_evt = '0; bus_wr = 1'b0;
    rd(2'd0, r);
    chk("R3 set wins", r, 16'h0040);
    wr(2'd0, 16'hFFFF);

    // R5 enabling an already pending source
    evt(16'h0200);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 16'h0200;
    edge_s();
    chk("R5 enable grants pulse", {15'd0, cpu_irq}, 16'd1);
    chk("R8 flag set by pulse", {15'd0, agg_flag}, 16'd1);
    @(negedge clk);
    bus_wr = 1'b0;
    // R8 polarity
    wr(2'd3, 16'h0002);
    chk("R8 write one keeps flag", {15'd0, agg_flag}, 16'd1);
    wr(2'd3, 16'h0000);
    chk("R8 write zero clears flag", {15'd0, agg_flag}, 16'd0);
    wr(2'd0, 16'hFFFF);

    // R6 chained pulse on clear
    wr(2'd1, 16'hFFFF);
    evt(16'h0088);
    wr(2'd3, 16'h0000);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 16'h0008;
    edge_s();
    chk("R6 next pulse after clear", {15'd0, cpu_irq}, 16'd1);
    chk("R6 flag set again", {15'd0, agg_flag}, 16'd1);
    @(negedge clk);
    bus_wr = 1'b0;
    rd(2'd2, r);
    chk("R6 vector moves on", r, 16'h001C);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 16'h0080;
    edge_s();
    chk("R7 no pulse when none remain", {15'd0, cpu_irq}, 16'd0);
    @(negedge clk);
    bus_wr = 1'b0;
    rd(2'd2, r);
    chk("R4 vector empty", r, 16'h0000);

    // R8 pulse wins over same-cycle zero-write
    wr(2'd3, 16'h0000);
    @(negedge clk);
    src_evt = 16'h0001; bus_wr = 1'b1; bus_addr = 2'd3; bus_wdata = 16'h0000;
    edge_s();
    chk("R8 pulse wins over clear", {15'd0, agg_flag}, 16'd1);
    @(negedge clk);
    src_evt = '0; bus_wr = 1'b0;
    wr(2'd0, 16'hFFFF);

    // R9 autovector substitution
    wr(2'd3, 16'h0001);
    evt(16'h0800);
    mem_data = 8'hA5;
    fetch_addr = 16'h0045;
    #1;
    chk("R9 substituted byte", {8'd0, fetch_data}, 16'h002C);
    fetch_addr = 16'h0046;
    #1;
    chk("R9 other address passes", {8'd0, fetch_data}, 16'h00A5);
    rd(2'd3, r);
    chk("R9 control readback", r, 16'h0003);
    wr(2'd3, 16'h0000);
    fetch_addr = 16'h0045;
    #1;
    chk("R9 disabled passes", {8'd0, fetch_data}, 16'h00A5);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule